// File: doc/BRIEF.md
# Polyphase FIR Interpolator

This block raises the sample rate of a single stream by an integer factor `PHASES` (L). It is a FIR interpolator arranged as L sub-filters that share one input delay line. When a low-rate sample is accepted, every sub-filter sees the same history at once. Sub-filter p applies only its own coefficient subset, h[p], h[p+L], h[p+2L] and so on, so it yields one fractional-delay output. An output sequencer then releases the L results one after another on a ready/valid stream. The block never inserts zeros and never multiplies one, because upsampling and filtering happen in the same structure.

The coefficient set enters on a static input vector. This lets the same hardware run any prototype filter of `PHASES * TAPS` taps. The input side is valid/ready as well. The block takes a new sample only after the downstream side has taken all L outputs of the previous one. Each result keeps full precision through the sum. A fixed window of `OUT_W` bits, starting at bit `SHIFT`, is then taken from it.

Top module: `polyphase_interp`

## Requirements
- R1: While reset is held and on the first cycle after reset, `inReady` is 1 and `outValid` is 0.
- R2: When a sample is accepted (`inValid` and `inReady` high at a rising clock edge), `outValid` is 1 and `inReady` is 0 in the following cycle.
- R3: Each accepted sample produces exactly L outputs, one per phase, in the order p = 0, 1, …, L-1. One output is consumed on each cycle in which `outValid` and `outReady` are both high.
- R4: With x[n-k] the k-th most recent accepted sample (k = 0 is the newest), the output of phase p is the full-precision signed sum over k = 0..TAPS-1 of h[p + k·L]·x[n-k]. It is arithmetically shifted right by `SHIFT` and cut to its low `OUT_W` bits. Coefficient i is the two's-complement field `coefFlat[i*COEF_W +: COEF_W]`, and samples are two's complement.
- R5: After reset the delay line holds zeros, so samples that came before the first accepted one count as zero.
- R6: While `outValid` is 1 and `outReady` is 0, `outValid` stays 1 and `outData` does not change.
- R7: A sample offered while `inReady` is 0 is ignored and never enters the delay line.
- R8: In the cycle after the last phase of a sample is consumed, `inReady` is 1 and `outValid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| coefFlat | input | PHASES*TAPS*COEF_W | Prototype filter coefficients, coefficient i at bits i*COEF_W upward |
| inValid | input | 1 | Low-rate sample offered |
| inReady | output | 1 | Block can take a sample |
| inData | input | DATA_W | Low-rate sample, two's complement |
| outValid | output | 1 | High-rate output present |
| outReady | input | 1 | Downstream takes the output |
| outData | output | OUT_W | High-rate output sample |

## Verification
The hardest case to reach is a sample offered while the block is still busy with the previous one. It must leave no trace, and the only place its absence shows is in the arithmetic of later outputs. The bench therefore holds `inValid` high with garbage data through every emission window and drops it only on the cycle of the final handshake. It also inserts stalls on `outReady` in an uneven pattern, so that holds appear at every phase position. Every output is compared against a dot product computed in the bench from a model history. This runs over three coefficient sets, including all-extreme values that use the full accumulator range.

// File: rtl/polyphase_pkg.sv
package polyphase_pkg;

  // Strobes issued by the control FSM to the datapath each cycle
  typedef struct packed {
    logic shiftIn;     // push the accepted sample into the delay line
    logic resetPhase;  // restart output sequencing at phase 0
    logic stepPhase;   // advance to the next phase
  } ctrlStrobe_t;

endpackage

// File: rtl/polyphase_tap_lane.sv
module polyphase_tap_lane #(
  parameter int DATA_W = 8,
  parameter int COEF_W = 8,
  parameter int ACC_W  = 18
) (
  input  logic signed [DATA_W-1:0] sample,
  input  logic signed [COEF_W-1:0] coef,
  output logic signed [ACC_W-1:0]  product
);

  // Signed product, sign-extended into the accumulator width
  always_comb begin
    product = ACC_W'(sample * coef);
  end

endmodule

// File: rtl/polyphase_ctrl.sv
module polyphase_ctrl
  import polyphase_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  output logic        inReady,
  output logic        outValid,
  input  logic        outReady,
  input  logic        lastPhase,
  output ctrlStrobe_t strobe
);

  logic busy;
  logic accept;
  logic fire;

  assign accept = inValid && !busy;
  assign fire   = busy && outReady;

  assign inReady  = !busy;
  assign outValid = busy;

  always_comb begin
    strobe            = '0;
    strobe.shiftIn    = accept;
    strobe.resetPhase = accept;
    strobe.stepPhase  = fire && !lastPhase;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy <= 1'b0;
    end else if (accept) begin
      busy <= 1'b1;
    end else if (fire && lastPhase) begin
      busy <= 1'b0;
    end
  end

endmodule

// File: rtl/polyphase_datapath.sv
module polyphase_datapath
  import polyphase_pkg::*;
#(
  parameter int PHASES = 4,
  parameter int TAPS   = 3,
  parameter int DATA_W = 8,
  parameter int COEF_W = 8,
  parameter int OUT_W  = 12,
  parameter int SHIFT  = 6,
  parameter int ACC_W  = 18,
  parameter int PH_W   = 2
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  ctrlStrobe_t                   strobe,
  input  logic [PHASES*TAPS*COEF_W-1:0] coefFlat,
  input  logic [DATA_W-1:0]             inData,
  output logic [PH_W-1:0]               phaseIdx,
  output logic                          lastPhase,
  output logic [OUT_W-1:0]              outData
);

  logic signed [DATA_W-1:0] history [TAPS];
  logic signed [ACC_W-1:0]  laneProd [TAPS];
  logic signed [ACC_W-1:0]  accSum;

  // Shared delay line, entry 0 holds the newest sample
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < TAPS; k++) history[k] <= '0;
    end else if (strobe.shiftIn) begin
      history[0] <= inData;
      for (int k = 1; k < TAPS; k++) history[k] <= history[k-1];
    end
  end

  // Output phase counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseIdx <= '0;
    end else if (strobe.resetPhase) begin
      phaseIdx <= '0;
    end else if (strobe.stepPhase) begin
      phaseIdx <= phaseIdx + 1'b1;
    end
  end

  assign lastPhase = (phaseIdx == PH_W'(PHASES - 1));

  // One multiplier lane per tap; the coefficient is picked by the current phase
  for (genvar k = 0; k < TAPS; k++) begin : g_lane
    logic signed [COEF_W-1:0] laneCoef;
    assign laneCoef = coefFlat[(int'(phaseIdx) + k*PHASES)*COEF_W +: COEF_W];

    polyphase_tap_lane #(
      .DATA_W(DATA_W),
      .COEF_W(COEF_W),
      .ACC_W (ACC_W)
    ) u_lane (
      .sample (history[k]),
      .coef   (laneCoef),
      .product(laneProd[k])
    );
  end

  // Full-precision sum, then a fixed output window
  always_comb begin
    accSum = '0;
    for (int k = 0; k < TAPS; k++) accSum = accSum + laneProd[k];
  end

  assign outData = OUT_W'(accSum >>> SHIFT);

endmodule

// File: rtl/polyphase_interp.sv
module polyphase_interp
  import polyphase_pkg::*;
#(
  parameter int PHASES = 4,
  parameter int TAPS   = 3,
  parameter int DATA_W = 8,
  parameter int COEF_W = 8,
  parameter int OUT_W  = 12,
  parameter int SHIFT  = 6
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [PHASES*TAPS*COEF_W-1:0] coefFlat,
  input  logic                          inValid,
  output logic                          inReady,
  input  logic [DATA_W-1:0]             inData,
  output logic                          outValid,
  input  logic                          outReady,
  output logic [OUT_W-1:0]              outData
);

  localparam int ACC_W = DATA_W + COEF_W + $clog2(TAPS + 1);
  localparam int PH_W  = (PHASES > 1) ? $clog2(PHASES) : 1;

  ctrlStrobe_t     strobe;
  logic [PH_W-1:0] phaseIdx;
  logic            lastPhase;

  polyphase_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inReady  (inReady),
    .outValid (outValid),
    .outReady (outReady),
    .lastPhase(lastPhase),
    .strobe   (strobe)
  );

  polyphase_datapath #(
    .PHASES(PHASES),
    .TAPS  (TAPS),
    .DATA_W(DATA_W),
    .COEF_W(COEF_W),
    .OUT_W (OUT_W),
    .SHIFT (SHIFT),
    .ACC_W (ACC_W),
    .PH_W  (PH_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .coefFlat (coefFlat),
    .inData   (inData),
    .phaseIdx (phaseIdx),
    .lastPhase(lastPhase),
    .outData  (outData)
  );

endmodule

// File: rtl/polyphase_interp_chk.sv
module polyphase_interp_chk #(
  parameter int PHASES = 4,
  parameter int PH_W   = 2,
  parameter int OUT_W  = 12
) (
  input logic             clk,
  input logic             rstN,
  input logic             inValid,
  input logic             inReady,
  input logic             outValid,
  input logic             outReady,
  input logic [OUT_W-1:0] outData,
  input logic [PH_W-1:0]  phaseIdx
);

  // R2
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> (outValid && !inReady && phaseIdx == '0));

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData) && $stable(phaseIdx)));

  // R3
  phase_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outReady && phaseIdx != PH_W'(PHASES - 1))
      |=> (outValid && phaseIdx == PH_W'($past(phaseIdx) + 1'b1)));

  // R8
  release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outReady && phaseIdx == PH_W'(PHASES - 1)) |=> (inReady && !outValid));

  // R7
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!inReady && outValid && !outReady) |=> !inReady);

endmodule

bind polyphase_interp polyphase_interp_chk #(
  .PHASES(PHASES),
  .PH_W  (PH_W),
  .OUT_W (OUT_W)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .inValid (inValid),
  .inReady (inReady),
  .outValid(outValid),
  .outReady(outReady),
  .outData (outData),
  .phaseIdx(phaseIdx)
);

// File: tb/tb_polyphase_interp.sv
module tb_polyphase_interp;

  localparam int CLK_PERIOD = 10;
  localparam int PHASES = 4;
  localparam int TAPS   = 3;
  localparam int DATA_W = 8;
  localparam int COEF_W = 8;
  localparam int OUT_W  = 12;
  localparam int SHIFT  = 6;
  localparam int NCOEF  = PHASES * TAPS;
  localparam int NSAMP  = 14;

  logic                    clk = 1'b0;
  logic                    rstN = 1'b0;
  logic [NCOEF*COEF_W-1:0] coefFlat = '0;
  logic                    inValid = 1'b0;
  logic                    inReady;
  logic [DATA_W-1:0]       inData = '0;
  logic                    outValid;
  logic                    outReady = 1'b0;
  logic [OUT_W-1:0]        outData;

  int vectors = 0;
  int fails = 0;
  int cycles = 0;
  int coefTab [NCOEF];
  int hist [TAPS];
  int stallCnt = 0;

  polyphase_interp #(
    .PHASES(PHASES), .TAPS(TAPS), .DATA_W(DATA_W),
    .COEF_W(COEF_W), .OUT_W(OUT_W), .SHIFT(SHIFT)
  ) dut (
    .clk(clk), .rstN(rstN), .coefFlat(coefFlat),
    .inValid(inValid), .inReady(inReady), .inData(inData),
    .outValid(outValid), .outReady(outReady), .outData(outData)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      fails = fails + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors = vectors + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int coefOf(input int setSel, input int i);
    case (setSel)
      0: return i + 1;
      1: return (i % 2 == 0) ? -128 : 127;
      default: return ((i * 53 + 17) % 256) - 128;
    endcase
  endfunction

  function automatic int sampleOf(input int setSel, input int n);
    if (n == 0) return 127;
    if (n == 1) return -128;
    return ((n * 71 + setSel * 29 + 5) % 256) - 128;
  endfunction

  // Expected output of phase p from the model history (R4)
  function automatic logic [OUT_W-1:0] expectOut(input int p);
    int acc = 0;
    for (int k = 0; k < TAPS; k++) acc += coefTab[p + k*PHASES] * hist[k];
    return OUT_W'(acc >>> SHIFT);
  endfunction

  task automatic applyReset();
    @(negedge clk);
    rstN = 1'b0;
    inValid = 1'b0;
    outReady = 1'b0;
    @(negedge clk);
    // R1: state during reset
    check(inReady == 1'b1 && outValid == 1'b0, "R1", {inReady, outValid}, 2);
    rstN = 1'b1;
    @(negedge clk);
    // R1: first cycle after reset
    check(inReady == 1'b1 && outValid == 1'b0, "R1", {inReady, outValid}, 2);
    for (int k = 0; k < TAPS; k++) hist[k] = 0;  // R5: history zero
  endtask

  task automatic sendAndCollect(input int x, input int junk);
    inValid = 1'b1;
    inData = DATA_W'(x);
    while (!inReady) @(negedge clk);
    @(negedge clk);
    for (int k = TAPS-1; k > 0; k--) hist[k] = hist[k-1];
    hist[0] = x;
    // R2: busy right after acceptance
    check(outValid == 1'b1 && inReady == 1'b0, "R2", {outValid, inReady}, 2);
    // R7: offer garbage while busy
    inData = DATA_W'(junk);
    for (int p = 0; p < PHASES; p++) begin
      logic [OUT_W-1:0] held;
      bit stall;
      stall = ((stallCnt % 3) == 1) || ((stallCnt % 7) == 4);
      stallCnt++;
      if (stall) begin
        outReady = 1'b0;
        held = outData;
        @(negedge clk);
        // R6: held output under backpressure
        check(outValid == 1'b1 && outData == held, "R6", int'(outData), int'(held));
      end
      // R4 / R3 / R5: phase-ordered value
      check(outValid == 1'b1 && outData == expectOut(p), "R4",
            int'(outData), int'(expectOut(p)));
      outReady = 1'b1;
      if (p == PHASES-1) inValid = 1'b0;
      @(negedge clk);
    end
    outReady = 1'b0;
    // R8 / R3: released after exactly PHASES outputs
    check(inReady == 1'b1 && outValid == 1'b0, "R8", {inReady, outValid}, 2);
  endtask

  initial begin
    for (int s = 0; s < 3; s++) begin
      for (int i = 0; i < NCOEF; i++) begin
        coefTab[i] = coefOf(s, i);
        coefFlat[i*COEF_W +: COEF_W] = COEF_W'(coefTab[i]);
      end
      applyReset();
      for (int n = 0; n < NSAMP; n++) begin
        sendAndCollect(sampleOf(s, n), sampleOf(s + 5, n + 3) ^ 8'h5a);
      end
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule